// File: doc/BRIEF.md
# Address Breakpoint Match Unit

This block watches a 16-bit processor address bus and raises a break flag when the bus equals a breakpoint address that software has programmed. The flag drives an external breakpoint output pin directly, so a debugger or logic analyser can stop on a chosen address.

Software reaches the block through a small synchronous register port. The port holds a control/status byte and the breakpoint address, which is split into a high byte and a low byte. The control byte chooses how the flag behaves. In latched mode the flag stays set until software clears it. In pulse mode it fires for a fixed number of clocks and then drops without any clear. The control byte also stores an auto-vector enable bit that plays no part in breakpoints. The bit only holds its value and reads it back.

Top module: `addr_break_unit`

## Requirements
- R1: After reset, the control byte, the breakpoint high byte and the breakpoint low byte all read 0x00, and `brk_pin` is 0.
- R2: Selector 1 writes and reads the breakpoint address bits 15:8, and selector 2 writes and reads bits 7:0. Reading selector 3 returns 0x00.
- R3: When the enable bit (control bit 1) is 1 and `cpu_addr` equals the full 16-bit breakpoint address in a cycle, the break flag is 1 from the next clock edge on. An address that differs in any single bit sets no flag.
- R4: While the enable bit is 0, no address on `cpu_addr` sets the break flag.
- R5: In latched mode (control bit 2 = 0) a set flag stays 1 until software writes the control byte with bit 3 = 1, which clears it at that write's edge. A control write with bit 3 = 0 leaves the flag as it was.
- R6: If a match and a clear write fall in the same cycle, the match wins and the flag stays 1.
- R7: In pulse mode (control bit 2 = 1), a single match holds the flag at 1 for exactly 8 clock cycles. The flag then returns to 0 with no software action.
- R8: A match that comes while a pulse is running restarts the count. The flag stays 1 for 8 cycles after the most recent match.
- R9: `brk_pin` always equals the break flag, which reads back as control bit 3.
- R10: Control bit 0 (auto-vector enable) is stored and read back, and it does not change breakpoint behaviour in either mode.
- R11: Control bits 7:4 always read 0 and ignore writes. Writing 1 to bit 3 never sets the flag.
- R12: A clear write (bit 3 = 1) during a running pulse ends it at that write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address bus under watch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 address high, 2 address low |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target, same encoding; 3 reads 0x00 |
| rd_data | output | 8 | Combinational read data for `rd_sel` |
| brk_pin | output | 1 | Breakpoint output, equal to the break flag |

## Verification
A match, a clear write or a register write shows at `brk_pin` and `rd_data` one clock edge after the cycle that presents it. A pulse ends on the eighth edge after its last match. `rd_data` follows `rd_sel` within the same cycle. A behavioural model updates on every rising edge from the inputs that were stable before it. Both outputs are compared against the model 2 ns after each edge, well before the inputs change on the falling edge. Directed checks of pulse length count the high samples from that same sample point.

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter int PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic [1:0]  rd_sel,
  output logic [7:0]  rd_data,
  output logic        brk_pin
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_LO   = 2'd2;

  logic [15:0]      bp_addr;
  logic             av_q, en_q, pulse_q, flag_q;
  logic [CNT_W-1:0] cnt_q;

  wire hit = en_q && (cpu_addr == bp_addr);
  wire clr = wr_en && (wr_sel == SEL_CTRL) && wr_data[3];
  wire unused_ok = &{1'b0, wr_data[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_addr <= '0;
      av_q    <= 1'b0;
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: begin
            av_q    <= wr_data[0];
            en_q    <= wr_data[1];
            pulse_q <= wr_data[2];
          end
          SEL_HI:  bp_addr[15:8] <= wr_data;
          SEL_LO:  bp_addr[7:0]  <= wr_data;
          default: ;
        endcase
      end
      if (hit) begin
        flag_q <= 1'b1;
        cnt_q  <= CNT_W'(PULSE_LEN - 1);
      end else if (clr) begin
        flag_q <= 1'b0;
        cnt_q  <= '0;
      end else if (pulse_q && flag_q) begin
        if (cnt_q != '0) cnt_q  <= cnt_q - 1'b1;
        else             flag_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = {4'b0000, flag_q, pulse_q, en_q, av_q};
      SEL_HI:   rd_data = bp_addr[15:8];
      SEL_LO:   rd_data = bp_addr[7:0];
      default:  rd_data = 8'h00;
    endcase
  end

  assign brk_pin = flag_q;
endmodule

// File: rtl/addr_break_unit_chk.sv
module addr_break_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [15:0] bp_addr,
  input logic        en_q,
  input logic        pulse_q,
  input logic        flag_q,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic [1:0]  rd_sel,
  input logic [7:0]  rd_data,
  input logic        brk_pin
);
  p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cpu_addr == bp_addr) |=> brk_pin);

  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !brk_pin) |=> !brk_pin);

  p_latch_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_pin && !pulse_q && !(wr_en && wr_sel == 2'd0 && wr_data[3])) |=> brk_pin);

  p_pin_mirrors_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> (rd_data[3] == brk_pin));

  p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> (rd_data[7:4] == 4'h0));

  p_flag_is_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q == brk_pin);
endmodule

bind addr_break_unit addr_break_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .bp_addr(bp_addr),
  .en_q(en_q), .pulse_q(pulse_q), .flag_q(flag_q), .wr_en(wr_en),
  .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
  .brk_pin(brk_pin)
);

// File: tb/test_addr_break_unit.sv
`timescale 1ns/100ps
module test_addr_break_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  rd_sel = 2'd0;
  logic [7:0]  rd_data;
  logic        brk_pin;

  int checks = 0, errors = 0, hi_count = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model state
  bit m_flag, m_en, m_pulse, m_av;
  int m_left;
  logic [15:0] m_bp;

  always #2.5 clk = ~clk;

  addr_break_unit i_addr_break_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .brk_pin(brk_pin)
  );

  function automatic logic [7:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0: return {4'b0000, m_flag, m_pulse, m_en, m_av};
      2'd1: return m_bp[15:8];
      2'd2: return m_bp[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, clr;
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_pulse = 0; m_av = 0; m_left = 0; m_bp = 16'h0000;
    end else begin
      hit = m_en && (cpu_addr == m_bp);
      clr = wr_en && wr_sel == 2'd0 && wr_data[3];
      if (hit) begin m_flag = 1; m_left = 7; end
      else if (clr) begin m_flag = 0; m_left = 0; end
      else if (m_pulse && m_flag) begin
        if (m_left > 0) m_left--; else m_flag = 0;
      end
      if (wr_en) begin
        if (wr_sel == 2'd0) begin m_av = wr_data[0]; m_en = wr_data[1]; m_pulse = wr_data[2]; end
        else if (wr_sel == 2'd1) m_bp[15:8] = wr_data;
        else if (wr_sel == 2'd2) m_bp[7:0] = wr_data;
      end
    end
    #2;
    if (rst_n && !finished) begin
      check({tag, "/R9 pin"}, {7'd0, brk_pin}, {7'd0, m_flag});
      check({tag, " read"}, rd_data, exp_rd(rd_sel));
      if (brk_pin) hi_count++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic hit_once(logic [15:0] a);
    @(negedge clk); cpu_addr = a;
    @(negedge clk); cpu_addr = 16'h0000;
  endtask

  task automatic rd_chk(string req, logic [1:0] s, logic [7:0] exp);
    @(negedge clk); rd_sel = s; #0.5;
    check(req, rd_data, exp);
    rd_sel = 2'd0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); #0.5;
    check("R1 ctrl", rd_data, 8'h00);
    check("R1 pin", {7'd0, brk_pin}, 8'h00);
    @(negedge clk); rst_n = 1;
    rd_chk("R1 hi", 2'd1, 8'h00);
    rd_chk("R1 lo", 2'd2, 8'h00);

    tag = "R2";
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    rd_chk("R2 hi", 2'd1, 8'hA5);
    rd_chk("R2 lo", 2'd2, 8'h3C);
    rd_chk("R2 sel3", 2'd3, 8'h00);

    tag = "R4";
    @(negedge clk); cpu_addr = 16'hA53C; cyc(6); cpu_addr = 16'h0000; cyc(1);
    check("R4 no break", {7'd0, brk_pin}, 8'h00);

    tag = "R3";
    wr(2'd0, 8'h02);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cpu_addr = 16'hA53C ^ (16'h1 << i);
    end
    @(negedge clk); cpu_addr = 16'h0000;
    check("R3 near miss", {7'd0, brk_pin}, 8'h00);
    hit_once(16'hA53C);
    check("R3 match", {7'd0, brk_pin}, 8'h01);

    tag = "R5";
    cyc(20);
    check("R5 held", {7'd0, brk_pin}, 8'h01);
    wr(2'd0, 8'h02);
    check("R5 zero write", {7'd0, brk_pin}, 8'h01);
    wr(2'd0, 8'h0A);
    check("R5 cleared", {7'd0, brk_pin}, 8'h00);

    tag = "R6";
    @(negedge clk); cpu_addr = 16'hA53C; wr_en = 1; wr_sel = 2'd0; wr_data = 8'h0A;
    @(negedge clk); cpu_addr = 16'h0000; wr_en = 0;
    check("R6 match wins", {7'd0, brk_pin}, 8'h01);
    wr(2'd0, 8'h0A);

    tag = "R7";
    wr(2'd0, 8'h06); cyc(2); hi_count = 0;
    hit_once(16'hA53C); cyc(14);
    check("R7 pulse length", hi_count[7:0], 8'd8);
    check("R7 self clear", {7'd0, brk_pin}, 8'h00);

    tag = "R8";
    hi_count = 0;
    @(negedge clk); cpu_addr = 16'hA53C;
    @(negedge clk); cpu_addr = 16'h0000; cyc(3);
    cpu_addr = 16'hA53C;
    @(negedge clk); cpu_addr = 16'h0000; cyc(16);
    check("R8 restarted length", hi_count[7:0], 8'd12);

    tag = "R10";
    wr(2'd0, 8'h07);
    rd_chk("R10 readback", 2'd0, 8'h07);
    hi_count = 0; hit_once(16'hA53C); cyc(14);
    check("R10 pulse unchanged", hi_count[7:0], 8'd8);
    wr(2'd0, 8'h03);
    hit_once(16'hA53C); cyc(12);
    check("R10 latched unchanged", {7'd0, brk_pin}, 8'h01);

    tag = "R11";
    wr(2'd0, 8'hFE);
    rd_chk("R11 upper and flag", 2'd0, 8'h06);
    wr(2'd0, 8'hF6);
    rd_chk("R11 no set by write", 2'd0, 8'h06);

    tag = "R12";
    hi_count = 0;
    hit_once(16'hA53C); cyc(2);
    wr(2'd0, 8'h0E);
    check("R12 early end", {7'd0, brk_pin}, 8'h00);
    cyc(10);
    check("R12 stays low", {7'd0, brk_pin}, 8'h00);

    tag = "R9";
    hit_once(16'hA53C); #0.5;
    check("R9 pin vs bit3", {7'd0, brk_pin}, {7'd0, rd_data[3]});
    cyc(12);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule